// File: doc/BRIEF.md
# Paired PWM Compare Output Generator

This block turns the event pulses of one 16-bit PWM timer channel in comparator mode into two output waveforms, one for each circuit in a pair. Each circuit watches its own comparator MATCH pulse, the MATCH pulse of its partner circuit, and the counter's MAX and ZERO pulses. A 3-bit waveform mode chooses which of these events sets, clears or toggles the circuit's waveform state. The state then passes through a per-circuit polarity invert into a registered output pin.

If a circuit's partner-match select is enabled, its partner's MATCH can drive the opposite edge. The output can then change twice in one counter period without waiting for MAX or ZERO. A channel that needs four or six outputs sets `NUM_PAIRS` higher. Circuit 2k is always paired with circuit 2k+1.

Every input event is a single-cycle pulse. The result appears on the pin at the clock edge that samples the event.

Top module: `pwm_pair_out`

## Requirements
- R1: While `rst_ni` is low, every bit of `wave_o` is 0 and every waveform state is cleared to inactive (0).
- R2: In mode 000 or mode 111, the waveform state loads `manual_i` at every clock edge. `wave_o` equals `manual_i ^ inv_i` as sampled at the previous edge.
- R3: In mode 001, the circuit's own MATCH sets the state to 1, and MAX or ZERO clears it to 0. When both arrive in the same cycle, own MATCH wins. The partner-match select has no effect in this mode.
- R4: In mode 010, own MATCH clears the state and MAX or ZERO sets it. When both arrive in the same cycle, own MATCH wins.
- R5: In mode 011, own MATCH toggles the state. MAX, ZERO and the partner's MATCH are ignored.
- R6: In mode 100 with partner-match select 1, own MATCH sets the state and the partner's MATCH clears it. MAX and ZERO are ignored. When both MATCH pulses arrive together, own MATCH wins.
- R7: In mode 101 with partner-match select 1, own MATCH clears the state and the partner's MATCH sets it. When both arrive together, own MATCH wins.
- R8: In mode 110 with partner-match select 1, the state toggles once in any cycle that has own MATCH, partner MATCH or both.
- R9: With partner-match select 0, modes 100, 101 and 110 behave as modes 001, 010 and 011.
- R10: `wave_o` bit i equals the new state of circuit i XOR `inv_i[i]`, registered. Invert 1 makes the active level low.
- R11: Changing the mode between non-manual modes, in a cycle with no event, leaves the state and the pin unchanged.
- R12: Circuits have independent controls. Circuit i's partner is circuit i XOR 1, so MATCH bit 0 is the partner of bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | NUM_OUT | Comparator MATCH pulse, one bit per circuit |
| cnt_max_i | input | 1 | Counter MAX pulse |
| cnt_zero_i | input | 1 | Counter ZERO pulse |
| mode_i | input | 3*NUM_OUT | Waveform mode; bits [3i+2:3i] control circuit i |
| manual_i | input | NUM_OUT | Manual level used in modes 000 and 111 |
| pair_sel_i | input | NUM_OUT | Partner-match select per circuit |
| inv_i | input | NUM_OUT | Polarity invert per circuit |
| wave_o | output | NUM_OUT | Registered output pins |

## Verification
The properties take the event inputs to be single-cycle pulses sampled at the clock. The toggle and hold properties also assume that the invert bit is unchanged across the cycles they span. The properties start only from the second edge after reset, because only then does the pin reflect the invert setting.

The scoreboard driver changes mode, manual level, partner select and invert only at the falling edge, together with the event pulses of that cycle. Every configuration change is therefore seen by both the design and the reference model at the same rising edge. The invert bit is changed only in cycles where no toggle-based check depends on it.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    WM_MANUAL   = 3'd0,
    WM_SET_MZ   = 3'd1,
    WM_CLR_MZ   = 3'd2,
    WM_TGL      = 3'd3,
    WM_SET_PAIR = 3'd4,
    WM_CLR_PAIR = 3'd5,
    WM_TGL_PAIR = 3'd6,
    WM_RSVD     = 3'd7
  } wave_mode_e;

  typedef struct packed {
    logic load;
    logic set;
    logic clr;
    logic tgl;
  } wave_cmd_t;
endpackage

// File: rtl/pwm_evt_decode.sv
module pwm_evt_decode
  import pwm_pair_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pair_sel_i,
  input  logic              own_i,
  input  logic              partner_i,
  input  logic              mz_i,
  output wave_cmd_t         cmd_o
);
  wave_mode_e eff_mode;

  // pair modes without partner select fold onto the MAX/ZERO modes
  always_comb begin
    eff_mode = wave_mode_e'(mode_i);
    if (!pair_sel_i && (mode_i >= 3'd4) && (mode_i <= 3'd6))
      eff_mode = wave_mode_e'(mode_i - 3'd3);
  end

  always_comb begin
    cmd_o = '0;
    unique case (eff_mode)
      WM_SET_MZ: begin
        cmd_o.set = own_i;
        cmd_o.clr = !own_i && mz_i;
      end
      WM_CLR_MZ: begin
        cmd_o.clr = own_i;
        cmd_o.set = !own_i && mz_i;
      end
      WM_TGL:    cmd_o.tgl = own_i;
      WM_SET_PAIR: begin
        cmd_o.set = own_i;
        cmd_o.clr = !own_i && partner_i;
      end
      WM_CLR_PAIR: begin
        cmd_o.clr = own_i;
        cmd_o.set = !own_i && partner_i;
      end
      WM_TGL_PAIR: cmd_o.tgl = own_i || partner_i;
      default:     cmd_o.load = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwm_wave_cell.sv
module pwm_wave_cell
  import pwm_pair_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wave_cmd_t cmd_i,
  input  logic      manual_i,
  input  logic      inv_i,
  output logic      pin_o
);
  logic state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cmd_i.load)     state_d = manual_i;
    else if (cmd_i.set) state_d = 1'b1;
    else if (cmd_i.clr) state_d = 1'b0;
    else if (cmd_i.tgl) state_d = !state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      pin_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      pin_o   <= state_d ^ inv_i;
    end
  end
endmodule

// File: rtl/pwm_pair_out.sv
module pwm_pair_out
  import pwm_pair_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 1,
  localparam int unsigned NUM_OUT = 2 * NUM_PAIRS,
  localparam int unsigned CFG_W   = MODE_W * NUM_OUT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OUT-1:0] match_i,
  input  logic               cnt_max_i,
  input  logic               cnt_zero_i,
  input  logic [CFG_W-1:0]   mode_i,
  input  logic [NUM_OUT-1:0] manual_i,
  input  logic [NUM_OUT-1:0] pair_sel_i,
  input  logic [NUM_OUT-1:0] inv_i,
  output logic [NUM_OUT-1:0] wave_o
);
  logic mz;
  assign mz = cnt_max_i | cnt_zero_i;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_circ
    localparam int unsigned PARTNER = g ^ 1;
    wave_cmd_t cmd;

    pwm_evt_decode u_dec (
      .mode_i     (mode_i[g*MODE_W +: MODE_W]),
      .pair_sel_i (pair_sel_i[g]),
      .own_i      (match_i[g]),
      .partner_i  (match_i[PARTNER]),
      .mz_i       (mz),
      .cmd_o      (cmd)
    );

    pwm_wave_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_i    (cmd),
      .manual_i (manual_i[g]),
      .inv_i    (inv_i[g]),
      .pin_o    (wave_o[g])
    );
  end
endmodule

// File: rtl/pwm_pair_out_chk.sv
module pwm_pair_out_chk #(
  parameter int unsigned NUM_PAIRS = 1,
  localparam int unsigned NUM_OUT = 2 * NUM_PAIRS,
  localparam int unsigned CFG_W   = 3 * NUM_OUT
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_OUT-1:0] match_i,
  input logic               cnt_max_i,
  input logic               cnt_zero_i,
  input logic [CFG_W-1:0]   mode_i,
  input logic [NUM_OUT-1:0] manual_i,
  input logic [NUM_OUT-1:0] pair_sel_i,
  input logic [NUM_OUT-1:0] inv_i,
  input logic [NUM_OUT-1:0] wave_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic mz;
  assign mz = cnt_max_i | cnt_zero_i;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    localparam int unsigned P = g ^ 1;
    logic [2:0] md;
    assign md = mode_i[g*3 +: 3];

    AST_MANUAL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && (md == 3'd0 || md == 3'd7) |=> wave_o[g] == ($past(manual_i[g]) ^ $past(inv_i[g]))); // R2
    AST_OWN_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && md == 3'd1 && match_i[g] |=> wave_o[g] == !$past(inv_i[g])); // R3
    AST_MZ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && md == 3'd1 && !match_i[g] && mz |=> wave_o[g] == $past(inv_i[g])); // R3
    AST_OWN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && md == 3'd2 && match_i[g] |=> wave_o[g] == $past(inv_i[g])); // R4
    AST_TGL_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && md == 3'd3 && match_i[g] && $stable(inv_i[g]) |=> wave_o[g] != $past(wave_o[g])); // R5
    AST_PAIR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && md == 3'd4 && pair_sel_i[g] && !match_i[g] && match_i[P]
      |=> wave_o[g] == $past(inv_i[g])); // R6
    AST_PAIR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && md == 3'd5 && pair_sel_i[g] && !match_i[g] && match_i[P]
      |=> wave_o[g] == !$past(inv_i[g])); // R7
    AST_FALLBACK_MZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && md == 3'd4 && !pair_sel_i[g] && !match_i[g] && mz
      |=> wave_o[g] == $past(inv_i[g])); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && md >= 3'd1 && md <= 3'd6 && !match_i[g] && !match_i[P] && !mz
      && $stable(inv_i[g]) |=> $stable(wave_o[g])); // R11
  end
endmodule

bind pwm_pair_out pwm_pair_out_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (.*);

// File: tb/pwm_pair_out_tb_top.sv
module pwm_pair_out_tb_top;
  localparam int N = 2;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] match_i = '0;
  logic         cnt_max_i = 1'b0;
  logic         cnt_zero_i = 1'b0;
  logic [3*N-1:0] mode_i = '0;
  logic [N-1:0] manual_i = '0;
  logic [N-1:0] pair_sel_i = '0;
  logic [N-1:0] inv_i = '0;
  logic [N-1:0] wave_o;

  pwm_pair_out #(.NUM_PAIRS(1)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] c_mode [N];
  logic [N-1:0] c_man = '0, c_pair = '0, c_inv = '0;
  logic st [N];

  function automatic logic nxt(logic [2:0] md, logic man, logic pr, logic own,
                               logic par, logic mz, logic s);
    logic [2:0] e;
    e = md;
    if (md >= 3'd4 && md <= 3'd6 && !pr) e = md - 3'd3;
    case (e)
      3'd1: return own ? 1'b1 : (mz ? 1'b0 : s);
      3'd2: return own ? 1'b0 : (mz ? 1'b1 : s);
      3'd3: return own ? !s : s;
      3'd4: return own ? 1'b1 : (par ? 1'b0 : s);
      3'd5: return own ? 1'b0 : (par ? 1'b1 : s);
      3'd6: return (own || par) ? !s : s;
      default: return man;
    endcase
  endfunction

  task automatic tick(input string tag, input logic [N-1:0] m, input logic mx, input logic zr);
    item_t it;
    @(negedge clk_i);
    match_i = m; cnt_max_i = mx; cnt_zero_i = zr;
    for (int i = 0; i < N; i++) mode_i[i*3 +: 3] = c_mode[i];
    manual_i = c_man; pair_sel_i = c_pair; inv_i = c_inv;
    for (int i = 0; i < N; i++) begin
      st[i] = nxt(c_mode[i], c_man[i], c_pair[i], m[i], m[i^1], mx | zr, st[i]);
      it.exp[i] = st[i] ^ c_inv[i];
    end
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (wave_o !== it.exp) begin
        errors++;
        $display("FAIL %s: wave_o=%b expected %b", it.tag, wave_o, it.exp);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    st[0] = 0; st[1] = 0;
    c_mode[0] = 3'd0; c_mode[1] = 3'd0;
    #12;
    checks++;
    if (wave_o !== 2'b00) begin
      errors++;
      $display("FAIL R1: wave_o=%b expected 00", wave_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 manual and reserved
    c_mode[0] = 3'd0; c_mode[1] = 3'd7; c_man = 2'b11;
    tick("R2", 2'b00, 0, 0);
    c_man = 2'b00;
    tick("R2", 2'b01, 1, 0);
    // R3
    c_mode[0] = 3'd1; c_mode[1] = 3'd1;
    tick("R3", 2'b01, 0, 0);
    tick("R3", 2'b00, 1, 0);
    tick("R3", 2'b01, 0, 1);
    c_pair = 2'b11;
    tick("R3", 2'b10, 0, 0);
    // R12 / R4 independent modes
    c_pair = 2'b00; c_mode[0] = 3'd2; c_mode[1] = 3'd1;
    tick("R12", 2'b11, 0, 0);
    tick("R4", 2'b00, 0, 1);
    tick("R4", 2'b01, 1, 0);
    // R5
    c_mode[0] = 3'd3; c_mode[1] = 3'd3; c_pair = 2'b11;
    tick("R5", 2'b01, 1, 1);
    tick("R5", 2'b11, 0, 0);
    tick("R5", 2'b00, 1, 0);
    // R6
    c_mode[0] = 3'd4; c_mode[1] = 3'd4;
    tick("R6", 2'b01, 0, 0);
    tick("R6", 2'b00, 1, 1);
    tick("R6", 2'b11, 0, 0);
    // R7
    c_mode[0] = 3'd5; c_mode[1] = 3'd5;
    tick("R7", 2'b01, 0, 0);
    tick("R7", 2'b10, 0, 0);
    tick("R7", 2'b11, 0, 0);
    // R8
    c_mode[0] = 3'd6; c_mode[1] = 3'd6;
    tick("R8", 2'b01, 0, 0);
    tick("R8", 2'b11, 0, 0);
    tick("R8", 2'b00, 1, 0);
    // R9 fallback
    c_pair = 2'b00; c_mode[0] = 3'd4; c_mode[1] = 3'd4;
    tick("R9", 2'b11, 0, 0);
    tick("R9", 2'b00, 1, 0);
    c_mode[0] = 3'd5; c_mode[1] = 3'd5;
    tick("R9", 2'b00, 0, 1);
    c_mode[0] = 3'd6; c_mode[1] = 3'd6;
    tick("R9", 2'b10, 0, 0);
    // R10 polarity
    c_inv = 2'b11;
    tick("R10", 2'b00, 0, 0);
    c_inv = 2'b01; c_mode[0] = 3'd0; c_man = 2'b01;
    tick("R10", 2'b00, 0, 0);
    // R11 mode change keeps state
    c_inv = 2'b00; c_mode[0] = 3'd1; c_mode[1] = 3'd1;
    tick("R11", 2'b11, 0, 0);
    c_mode[0] = 3'd3; c_mode[1] = 3'd2;
    tick("R11", 2'b00, 0, 0);
    c_mode[0] = 3'd6; c_mode[1] = 3'd5;
    tick("R11", 2'b00, 0, 0);
    tick("R11", 2'b00, 0, 0);

    while (q.size() > 0) @(posedge clk_i);
    #4;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule